// File: doc/BRIEF.md
# Two-Wire EEPROM Slave Protocol Engine

This block is the bus-facing controller of a byte-addressed nonvolatile store of up to 2048 bytes. A fast system clock oversamples the two bus wires. The engine finds START and STOP conditions and receives the slave address. It acknowledges the address when the address is its own, then carries out byte writes, page writes, current-address reads, random reads and sequential reads. SDA is never driven high. The engine only raises a pull-low enable, which the pad turns into an open-drain output.

The store is split into 256-byte blocks. The `BLOCKS` parameter (1, 2, 4 or 8) picks how many of the three address bits after the device type select a block and how many must match the strap pins. The write path sees received bytes as a valid/ready stream:
- `wr_valid_o` rises with `wr_addr_o` and `wr_data_o`, and all three hold steady until a cycle in which `wr_ready_i` is high.
- The write path must accept each byte before the next byte on the bus completes, which is at least eight SCL periods later.
- A one-cycle `prog_start_o` tells the write path to begin programming.
- While programming is in progress, the write path holds `busy_i` high.

Reads are served through a plain combinational port. `rd_data_i` must show the byte at `rd_addr_o` within two system clocks of any change of `rd_addr_o`.

Top module: `eep_slave_top`

## Requirements
- R1: A START (SDA falling while SCL is high) in any state restarts reception of the slave address. A STOP (SDA rising while SCL is high) is detected the same way. SDA changes while SCL is low are treated as data only.
- R2: Before the first START, and after any address that does not match, the engine ignores the bus until the next START and drives no acknowledge.
- R3: The address byte is {type[3:0], b3, b2, b1, rw} sent MSB first, and the type must be 4'b1010. For BLOCKS of 1, 2, 4 or 8, the lowest 0, 1, 2 or 3 of b1..b3 are block-select bits, with b1 as block bit 0. Each remaining bit b(k+1) must equal `strap_i[k]`.
- R4: The engine acknowledges a matching address, and every byte received in write mode, by pulling SDA low for the ninth clock. `sda_oe_o` changes only after a detected SCL falling edge, or when it is released by START or STOP.
- R5: In write mode, the first byte after the address loads the low 8 bits of the address counter. The high bits come from the block-select bits of the address byte.
- R6: Each data byte is offered on the write stream at the current counter value. The counter then increments within its 16-byte page, so the low 4 bits wrap and the upper bits stay. A pending offer holds valid, address and data until it is accepted.
- R7: A STOP that ends a write transfer in which at least one data byte was received gives one `prog_start_o` pulse. A STOP that ends a transfer with no data byte gives none.
- R8: In read mode the engine sends 8 bits MSB first, then releases SDA. If the master acknowledges (SDA low in the ninth clock), the engine sends the next byte. If the master does not, the engine drives nothing until the next START.
- R9: A random read is a write-mode address plus a word address, then a repeated START and a read-mode address. Its data starts at the loaded address.
- R10: Each byte sent increments the whole address counter, and the counter wraps from the last byte of the array to 0.
- R11: A read-mode address with no preceding word address reads from the address after the last byte accessed. The block bits of the address byte replace the counter's high bits.
- R12: While `busy_i` is high, the engine does not acknowledge its slave address.
- R13: A STOP in any state returns the engine to idle, releases SDA, and discards a partly received byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock level |
| sda_i | input | 1 | Bus data level (wired line) |
| strap_i | input | 3 | Address strap pins |
| busy_i | input | 1 | Internal programming in progress |
| sda_oe_o | output | 1 | Pull SDA low when 1 |
| rd_addr_o | output | ADDR_W | Address counter toward the array read port |
| rd_data_i | input | 8 | Array byte at rd_addr_o |
| wr_valid_o | output | 1 | Write stream valid |
| wr_ready_i | input | 1 | Write stream ready |
| wr_addr_o | output | ADDR_W | Write stream byte address |
| wr_data_o | output | 8 | Write stream byte |
| prog_start_o | output | 1 | One-cycle request to start programming |

## Verification
The bench targets these corner cases, each paired with the failure it would expose:
- A page write longer than 16 bytes: a counter that carries out of the page would overwrite the neighbouring page.
- A sequential read across the top of the array: a counter that saturates, or keeps the block bits, would repeat bytes.
- A wrong device type, a strap mismatch on a second engine with two blocks, and a busy poll: a decoder that ignores the fixed bits, or the busy input, would acknowledge.
- A STOP in the middle of a data byte, a START in the middle of the word address, and a master NACK followed by further clocks: a design that keeps stale bit counts would write a partial byte, miss the restart, or keep driving data onto the bus.

// File: rtl/eep_pkg.sv
package eep_pkg;
  localparam logic [3:0] DEV_TYPE = 4'b1010;
  localparam int STRAP_W = 3;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ACK_DRV,
    ST_ACK_HOLD,
    ST_RX,
    ST_TX,
    ST_TX_REL,
    ST_MACK,
    ST_TX_NEXT,
    ST_WAIT_STOP
  } eep_state_e;

  function automatic int blk_bits(input int blocks);
    int r;
    r = 0;
    while ((1 << r) < blocks) r++;
    return r;
  endfunction
endpackage

// File: rtl/eep_pin_sync.sv
module eep_pin_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic bus_start,
  output logic bus_stop
);
  logic [SYNC_STAGES-1:0] scl_ff, sda_ff;
  logic scl_h, sda_h, scl_s, sda_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_h  <= 1'b1;
      sda_h  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[SYNC_STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[SYNC_STAGES-2:0], sda_i};
      scl_h  <= scl_ff[SYNC_STAGES-1];
      sda_h  <= sda_ff[SYNC_STAGES-1];
    end
  end

  assign scl_s     = scl_ff[SYNC_STAGES-1];
  assign sda_s     = sda_ff[SYNC_STAGES-1];
  assign sda_lvl   = sda_s;
  assign scl_rise  = scl_s & ~scl_h;
  assign scl_fall  = ~scl_s & scl_h;
  assign bus_start = scl_s & scl_h & sda_h & ~sda_s;
  assign bus_stop  = scl_s & scl_h & ~sda_h & sda_s;
endmodule

// File: rtl/eep_addr_decode.sv
module eep_addr_decode #(
  parameter int BLOCKS = 8,
  localparam int BLK_BITS = eep_pkg::blk_bits(BLOCKS),
  localparam int BLK_W = (BLK_BITS == 0) ? 1 : BLK_BITS
) (
  input  logic [7:0]                  byte_i,
  input  logic [eep_pkg::STRAP_W-1:0] strap_i,
  output logic                        hit_o,
  output logic                        rw_o,
  output logic [BLK_W-1:0]            blk_o
);
  logic [eep_pkg::STRAP_W-1:0] bit_ok;
  logic [eep_pkg::STRAP_W-1:0] blk_all;

  for (genvar i = 0; i < eep_pkg::STRAP_W; i++) begin : g_bit
    if (i < BLK_BITS) begin : g_blk
      assign bit_ok[i]  = 1'b1;
      assign blk_all[i] = byte_i[1+i];
    end else begin : g_strap
      assign bit_ok[i]  = (byte_i[1+i] == strap_i[i]);
      assign blk_all[i] = 1'b0;
    end
  end

  assign blk_o = blk_all[BLK_W-1:0];
  assign rw_o  = byte_i[0];
  assign hit_o = (byte_i[7:4] == eep_pkg::DEV_TYPE) && (&bit_ok);
endmodule

// File: rtl/eep_addr_ctr.sv
module eep_addr_ctr #(
  parameter int BLOCKS = 8,
  parameter int PAGE_BYTES = 16,
  localparam int BLK_BITS = eep_pkg::blk_bits(BLOCKS),
  localparam int BLK_W = (BLK_BITS == 0) ? 1 : BLK_BITS,
  localparam int ADDR_W = 8 + BLK_BITS,
  localparam int PG_BITS = eep_pkg::blk_bits(PAGE_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_blk,
  input  logic [BLK_W-1:0]  blk_i,
  input  logic              ld_word,
  input  logic [7:0]        word_i,
  input  logic              inc_page,
  input  logic              inc_full,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0] addr_q, blk_merged;

  if (BLK_BITS > 0) begin : g_blk
    assign blk_merged = {blk_i[BLK_BITS-1:0], addr_q[7:0]};
  end else begin : g_noblk
    assign blk_merged = addr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) addr_q <= '0;
    else if (ld_word) addr_q[7:0] <= word_i;
    else if (ld_blk) addr_q <= blk_merged;
    else if (inc_full) addr_q <= addr_q + 1'b1;
    else if (inc_page) addr_q[PG_BITS-1:0] <= addr_q[PG_BITS-1:0] + 1'b1;
  end

  assign addr_o = addr_q;

  AST_PAGE_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_page && !ld_word && !ld_blk && !inc_full)
      |=> addr_q[ADDR_W-1:PG_BITS] == $past(addr_q[ADDR_W-1:PG_BITS])); // R6
  AST_FULL_INC: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_full && !ld_word && !ld_blk) |=> addr_q == $past(addr_q) + 1'b1); // R10
endmodule

// File: rtl/eep_xfer_fsm.sv
module eep_xfer_fsm #(
  parameter int ADDR_W = 11,
  parameter int BLK_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_lvl,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              bus_start,
  input  logic              bus_stop,
  input  logic              busy_i,
  input  logic              hit_i,
  input  logic              rw_i,
  input  logic [BLK_W-1:0]  blk_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        rd_data_i,
  input  logic              wr_ready_i,
  output logic [7:0]        rx_byte_o,
  output logic              ld_blk_o,
  output logic              ld_word_o,
  output logic              inc_page_o,
  output logic              inc_full_o,
  output logic              sda_oe_o,
  output logic              wr_valid_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [7:0]        wr_data_o,
  output logic              prog_start_o
);
  import eep_pkg::*;

  eep_state_e state_q, state_n;
  logic [2:0] cnt_q, cnt_n;
  logic [7:0] sh_q, sh_n, tx_q, tx_n;
  logic oe_q, oe_n, rw_q, rw_n, word_q, word_n, wrote_q, wrote_n;
  logic wv_q, wv_n, prog_q, prog_n;
  logic [ADDR_W-1:0] wa_q, wa_n;
  logic [7:0] wd_q, wd_n;
  logic [7:0] rx_byte;

  assign rx_byte = {sh_q[6:0], sda_lvl};
  assign rx_byte_o = rx_byte;

  always_comb begin
    state_n = state_q; cnt_n = cnt_q; sh_n = sh_q; tx_n = tx_q;
    oe_n = oe_q; rw_n = rw_q; word_n = word_q; wrote_n = wrote_q;
    wv_n = wv_q; wa_n = wa_q; wd_n = wd_q; prog_n = 1'b0;
    ld_blk_o = 1'b0; ld_word_o = 1'b0; inc_page_o = 1'b0; inc_full_o = 1'b0;
    if (wv_q && wr_ready_i) wv_n = 1'b0;
    if (bus_stop) begin
      state_n = ST_IDLE;
      oe_n    = 1'b0;
      prog_n  = wrote_q;
      wrote_n = 1'b0;
    end else if (bus_start) begin
      state_n = ST_ADDR;
      cnt_n   = '0;
      oe_n    = 1'b0;
      wrote_n = 1'b0;
    end else begin
      case (state_q)
        ST_ADDR: if (scl_rise) begin
          sh_n = rx_byte;
          if (cnt_q == 3'd7) begin
            if (hit_i && !busy_i) begin
              state_n  = ST_ACK_DRV;
              rw_n     = rw_i;
              word_n   = !rw_i;
              ld_blk_o = 1'b1;
            end else begin
              state_n = ST_IDLE;
            end
          end else cnt_n = cnt_q + 1'b1;
        end
        ST_ACK_DRV: if (scl_fall) begin
          oe_n    = 1'b1;
          state_n = ST_ACK_HOLD;
        end
        ST_ACK_HOLD: if (scl_fall) begin
          cnt_n = '0;
          if (rw_q) begin
            tx_n    = rd_data_i;
            oe_n    = ~rd_data_i[7];
            state_n = ST_TX;
          end else begin
            oe_n    = 1'b0;
            state_n = ST_RX;
          end
        end
        ST_RX: if (scl_rise) begin
          sh_n = rx_byte;
          if (cnt_q == 3'd7) begin
            state_n = ST_ACK_DRV;
            if (word_q) begin
              ld_word_o = 1'b1;
              word_n    = 1'b0;
            end else begin
              wv_n       = 1'b1;
              wa_n       = addr_i;
              wd_n       = rx_byte;
              inc_page_o = 1'b1;
              wrote_n    = 1'b1;
            end
          end else cnt_n = cnt_q + 1'b1;
        end
        ST_TX: begin
          if (scl_fall) begin
            tx_n = {tx_q[6:0], 1'b0};
            oe_n = ~tx_q[6];
          end
          if (scl_rise) begin
            if (cnt_q == 3'd7) begin
              state_n    = ST_TX_REL;
              inc_full_o = 1'b1;
            end else cnt_n = cnt_q + 1'b1;
          end
        end
        ST_TX_REL: if (scl_fall) begin
          oe_n    = 1'b0;
          state_n = ST_MACK;
        end
        ST_MACK: if (scl_rise) state_n = sda_lvl ? ST_WAIT_STOP : ST_TX_NEXT;
        ST_TX_NEXT: if (scl_fall) begin
          tx_n    = rd_data_i;
          oe_n    = ~rd_data_i[7];
          cnt_n   = '0;
          state_n = ST_TX;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE; cnt_q <= '0; sh_q <= '0; tx_q <= '0;
      oe_q <= 1'b0; rw_q <= 1'b0; word_q <= 1'b0; wrote_q <= 1'b0;
      wv_q <= 1'b0; wa_q <= '0; wd_q <= '0; prog_q <= 1'b0;
    end else begin
      state_q <= state_n; cnt_q <= cnt_n; sh_q <= sh_n; tx_q <= tx_n;
      oe_q <= oe_n; rw_q <= rw_n; word_q <= word_n; wrote_q <= wrote_n;
      wv_q <= wv_n; wa_q <= wa_n; wd_q <= wd_n; prog_q <= prog_n;
    end
  end

  assign sda_oe_o     = oe_q;
  assign wr_valid_o   = wv_q;
  assign wr_addr_o    = wa_q;
  assign wr_data_o    = wd_q;
  assign prog_start_o = prog_q;

  AST_OE_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(oe_q) |-> $past(scl_fall || bus_start || bus_stop)); // R4
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE) |-> !oe_q); // R2
  AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_stop |=> (state_q == ST_IDLE) && !oe_q); // R13
  AST_START_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_start && !bus_stop) |=> (state_q == ST_ADDR) && (cnt_q == 3'd0)); // R1
  AST_BUSY_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ADDR && scl_rise && cnt_q == 3'd7 && busy_i) |=> state_q == ST_IDLE); // R12
  AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wv_q && !wr_ready_i) |=> wv_q && $stable(wa_q) && $stable(wd_q)); // R6
  AST_PROG_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    prog_q |=> !prog_q); // R7
endmodule

// File: rtl/eep_slave_top.sv
module eep_slave_top #(
  parameter int BLOCKS = 8,
  parameter int PAGE_BYTES = 16,
  localparam int BLK_BITS = eep_pkg::blk_bits(BLOCKS),
  localparam int BLK_W = (BLK_BITS == 0) ? 1 : BLK_BITS,
  localparam int ADDR_W = 8 + BLK_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [2:0]        strap_i,
  input  logic              busy_i,
  output logic              sda_oe_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic [7:0]        rd_data_i,
  output logic              wr_valid_o,
  input  logic              wr_ready_i,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [7:0]        wr_data_o,
  output logic              prog_start_o
);
  logic sda_lvl, scl_rise, scl_fall, bus_start, bus_stop;
  logic hit, rw;
  logic [BLK_W-1:0] blk;
  logic [7:0] rx_byte;
  logic ld_blk, ld_word, inc_page, inc_full;
  logic [ADDR_W-1:0] addr;

  eep_pin_sync #(.SYNC_STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .sda_lvl(sda_lvl), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .bus_start(bus_start), .bus_stop(bus_stop));

  eep_addr_decode #(.BLOCKS(BLOCKS)) u_dec (
    .byte_i(rx_byte), .strap_i(strap_i), .hit_o(hit), .rw_o(rw), .blk_o(blk));

  eep_addr_ctr #(.BLOCKS(BLOCKS), .PAGE_BYTES(PAGE_BYTES)) u_ctr (
    .clk(clk), .rst_n(rst_n), .ld_blk(ld_blk), .blk_i(blk),
    .ld_word(ld_word), .word_i(rx_byte), .inc_page(inc_page),
    .inc_full(inc_full), .addr_o(addr));

  eep_xfer_fsm #(.ADDR_W(ADDR_W), .BLK_W(BLK_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .bus_start(bus_start), .bus_stop(bus_stop),
    .busy_i(busy_i), .hit_i(hit), .rw_i(rw), .blk_i(blk), .addr_i(addr),
    .rd_data_i(rd_data_i), .wr_ready_i(wr_ready_i), .rx_byte_o(rx_byte),
    .ld_blk_o(ld_blk), .ld_word_o(ld_word), .inc_page_o(inc_page),
    .inc_full_o(inc_full), .sda_oe_o(sda_oe_o), .wr_valid_o(wr_valid_o),
    .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o), .prog_start_o(prog_start_o));

  assign rd_addr_o = addr;
endmodule

// File: tb/sim_eep_slave_top.sv
module sim_eep_slave_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1, sda_m = 1'b1, busy = 1'b0, wr_ready = 1'b1;
  logic oe0, oe1, wv0, wv1, prog0, prog1;
  logic [10:0] ra0, wa0;
  logic [8:0] ra1, wa1;
  logic [7:0] wd0, wd1, rd0;
  wire sda_bus = sda_m & ~oe0 & ~oe1;

  logic [7:0] mem [0:2047];
  logic [7:0] exp_mem [0:2047];
  int total = 0, bad = 0, pcount = 0;
  logic [8:0] u1_last = '0;
  logic [10:0] cur = '0;

  always #5 clk = ~clk;

  eep_slave_top #(.BLOCKS(8)) u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus), .strap_i(3'b000),
    .busy_i(busy), .sda_oe_o(oe0), .rd_addr_o(ra0), .rd_data_i(rd0),
    .wr_valid_o(wv0), .wr_ready_i(wr_ready), .wr_addr_o(wa0), .wr_data_o(wd0),
    .prog_start_o(prog0));

  eep_slave_top #(.BLOCKS(2)) u1 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus), .strap_i(3'b101),
    .busy_i(busy), .sda_oe_o(oe1), .rd_addr_o(ra1), .rd_data_i(8'hFF),
    .wr_valid_o(wv1), .wr_ready_i(1'b1), .wr_addr_o(wa1), .wr_data_o(wd1),
    .prog_start_o(prog1));

  function automatic logic [7:0] seed_byte(input int a);
    return 8'(a * 37 + (a >> 5) + 8'h5A);
  endfunction

  assign rd0 = mem[ra0];

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 2048; i++) mem[i] <= seed_byte(i);
    end else if (wv0 && wr_ready) mem[wa0] <= wd0;
    if (prog0) pcount <= pcount + 1;
    if (wv1) u1_last <= wa1;
  end

  always @(negedge clk) wr_ready <= ($urandom % 4) != 0;

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_q();
    repeat (8) @(negedge clk);
  endtask

  task automatic bit_x(input logic d, output logic q, output logic q1);
    sda_m = d; wait_q(); scl = 1'b1; wait_q();
    q = sda_bus; q1 = oe1;
    wait_q(); scl = 1'b0; wait_q();
  endtask

  task automatic start_c();
    sda_m = 1'b1; wait_q(); scl = 1'b1; wait_q(); sda_m = 1'b0; wait_q();
    scl = 1'b0; wait_q();
  endtask

  task automatic stop_c();
    sda_m = 1'b0; wait_q(); scl = 1'b1; wait_q(); sda_m = 1'b1; wait_q();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack, output logic ack1);
    logic q, q1;
    for (int i = 7; i >= 0; i--) bit_x(b[i], q, q1);
    bit_x(1'b1, q, q1);
    ack = !q; ack1 = q1;
  endtask

  task automatic recv_byte(input logic nack, output logic [7:0] b);
    logic q, q1;
    for (int i = 7; i >= 0; i--) begin
      bit_x(1'b1, q, q1);
      b[i] = q;
    end
    bit_x(nack, q, q1);
  endtask

  task automatic wr_txn(input logic [10:0] a, input int n);
    logic k0, k1;
    logic [10:0] ea;
    logic [7:0] d;
    int pc;
    ea = a;
    start_c();
    send_byte({4'hA, a[10:8], 1'b0}, k0, k1);
    chk(k0, "R3 address ack", k0, 1);
    chk(k1 == (a[10:9] == 2'b10), "R3 strap match u1", k1, a[10:9] == 2'b10);
    send_byte(a[7:0], k0, k1);
    chk(k0, "R5 word ack", k0, 1);
    pc = pcount;
    for (int i = 0; i < n; i++) begin
      ea = {a[10:4], 4'(a[3:0] + i)};
      d = 8'($urandom);
      exp_mem[ea] = d;
      send_byte(d, k0, k1);
      chk(k0, "R4 data ack", k0, 1);
    end
    stop_c();
    wait_q();
    cur = {a[10:4], 4'(a[3:0] + n)};
    chk(pcount == pc + 1, "R7 prog pulse", pcount, pc + 1);
    if (a[10:9] == 2'b10)
      chk(u1_last == {a[8], ea[7:0]}, "R3 block bit u1", u1_last, {a[8], ea[7:0]});
  endtask

  task automatic rd_loop(input int n, input string tag);
    logic [7:0] b;
    for (int i = 0; i < n; i++) begin
      recv_byte(i == n - 1, b);
      chk(b == exp_mem[cur], tag, b, exp_mem[cur]);
      cur = cur + 1'b1;
    end
  endtask

  task automatic rd_rand(input logic [10:0] a, input int n, input logic do_stop);
    logic k0, k1;
    int pc;
    pc = pcount;
    start_c();
    send_byte({4'hA, a[10:8], 1'b0}, k0, k1);
    send_byte(a[7:0], k0, k1);
    start_c();
    send_byte({4'hA, a[10:8], 1'b1}, k0, k1);
    chk(k0, "R9 read address ack", k0, 1);
    cur = a;
    rd_loop(n, "R9 R10 random/sequential data");
    if (do_stop) begin
      stop_c();
      wait_q();
      chk(pcount == pc, "R7 no prog on dummy write", pcount, pc);
    end
  endtask

  task automatic rd_cur(input int n);
    logic k0, k1;
    start_c();
    send_byte({4'hA, cur[10:8], 1'b1}, k0, k1);
    chk(k0, "R11 current read ack", k0, 1);
    rd_loop(n, "R11 current address data");
    stop_c();
  endtask

  initial begin
    logic k0, k1, q, q1;
    int pc;
    void'($urandom(32'h1D5));
    for (int i = 0; i < 2048; i++) exp_mem[i] = seed_byte(i);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!oe0 && !wv0 && !prog0, "R13 reset idle", {oe0, wv0, prog0}, 0);

    // R2: traffic before any START is ignored
    for (int i = 0; i < 9; i++) bit_x(1'b0, q, q1);
    chk(!oe0, "R2 no drive before START", oe0, 0);
    stop_c();

    wr_txn(11'h123, 1);
    rd_rand(11'h123, 1, 1'b1);
    wr_txn(11'h23E, 20);                 // R6 page wrap
    rd_rand(11'h230, 16, 1'b1);
    rd_rand(11'h7FE, 4, 1'b1);           // R10 array wrap
    rd_cur(2);                           // R11

    // R2 wrong device type, then further bytes unanswered
    pc = pcount;
    start_c();
    send_byte(8'hB0, k0, k1);
    chk(!k0, "R2 wrong type no ack", k0, 0);
    send_byte(8'h00, k0, k1);
    chk(!k0, "R2 ignored until START", k0, 0);
    stop_c();

    // R12 busy poll
    busy = 1'b1;
    start_c();
    send_byte(8'hA0, k0, k1);
    chk(!k0, "R12 busy no ack", k0, 0);
    stop_c();
    busy = 1'b0;
    start_c();
    send_byte(8'hA0, k0, k1);
    chk(k0, "R12 ack after busy", k0, 1);
    stop_c();
    wait_q();
    chk(pcount == pc, "R7 no prog without data", pcount, pc);
    cur[10:8] = 3'b000;

    // R8 master NACK: engine stays off the bus
    rd_rand(11'h050, 1, 1'b0);
    for (int i = 0; i < 9; i++) begin
      bit_x(1'b1, q, q1);
      chk(q, "R8 released after nack", q, 1);
    end
    stop_c();

    // R13 STOP inside a data byte
    pc = pcount;
    start_c();
    send_byte(8'hA6, k0, k1);
    send_byte(8'h00, k0, k1);
    for (int i = 0; i < 4; i++) bit_x(1'b0, q, q1);
    stop_c();
    wait_q();
    chk(pcount == pc && sda_bus, "R13 stop mid byte", pcount, pc);
    cur = 11'h300;
    rd_cur(1);

    // R1 START inside the word address restarts
    start_c();
    send_byte({4'hA, cur[10:8], 1'b0}, k0, k1);
    for (int i = 0; i < 3; i++) bit_x(1'b1, q, q1);
    start_c();
    send_byte({4'hA, cur[10:8], 1'b1}, k0, k1);
    chk(k0, "R1 restart ack", k0, 1);
    rd_loop(1, "R1 restart data");
    stop_c();

    wr_txn(11'h512, 2);                  // R3 u1 block 1
    wr_txn(11'h312, 1);                  // R3 u1 strap mismatch

    for (int it = 0; it < 6; it++) begin
      logic [10:0] a;
      a = 11'($urandom);
      wr_txn(a, 1 + ($urandom % 18));
      rd_rand({a[10:4], 4'h0}, 16, 1'b1);
      rd_cur(1 + ($urandom % 3));
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=0 exp=1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule